// File: doc/BRIEF.md
# Serial Port Frame Start Selector

This block decides the cycle in which one direction (transmit or receive) of a synchronous serial port begins a frame. A three-bit mode field picks the start condition. The port can start freely, start together with the opposite direction, follow the level or the edges of its own frame-sync line, or, on the receive side only, follow a match reported by a bit-stream pattern detector. When the condition is met, the block issues a one-cycle start pulse. It then stays busy until the data path reports that the frame is done.

Two copies are used in a port, one per direction. A parameter selects which direction a copy serves. Each copy watches only its own frame-sync line, and its synchronous mode takes the start pulse of the other copy. The frame-sync line is asynchronous to the port clock and passes through a two-flop synchronizer. The reset is asynchronous and active low, and must be released synchronously to `clk` by the surrounding logic.

Top module: `sport_start_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `start_pulse`, `armed` and `busy` are all 0.
- R2: A high `enable` sampled at a clock edge makes `armed` 1 from that edge on. A low `enable` sampled at an edge returns the block to idle (`armed`=0, `busy`=0). `start_pulse` is 0 in every cycle in which `enable` is low.
- R3: Mode 0 (continuous) behaves differently by direction. A receive copy pulses in its first armed cycle. A transmit copy pulses in an armed cycle in which `word_wr` is 1.
- R4: Mode 1 (with the other side) pulses in the same cycle as `peer_start` while armed.
- R5: Mode 2 pulses while the synchronized frame-sync is 0. Mode 3 pulses while it is 1.
- R6: Mode 4 pulses on a falling edge of the frame-sync line and mode 5 on a rising edge. A change driven between clock edges k-1 and k is seen in the cycle after edge k+1 (one cycle, through two synchronizer flops).
- R7: Mode 6 pulses on either edge of the frame-sync line, with the same latency as R6.
- R8: In mode 7, a receive copy pulses in an armed cycle in which `cmp_match` is 1. A transmit copy never pulses in mode 7.
- R9: `start_pulse` lasts one cycle and moves the block from armed to busy. While busy, all triggers are ignored. A `frame_done` sampled while busy makes `armed` 1 from the next edge.
- R10: Inputs that the selected mode does not name have no effect. No pulse is issued unless `armed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Direction enable; low forces idle |
| mode | input | 3 | Start condition select (0..7, see requirements) |
| fsync_in | input | 1 | Asynchronous frame-sync line of this direction |
| peer_start | input | 1 | Start pulse of the opposite direction |
| word_wr | input | 1 | Transmit holding register written (transmit copy) |
| cmp_match | input | 1 | Pattern match from the receive comparator |
| frame_done | input | 1 | Current frame finished; re-arm |
| start_pulse | output | 1 | One-cycle frame start |
| armed | output | 1 | Waiting for a start condition |
| busy | output | 1 | Frame in progress |

## Verification
Each mode is run on a receive copy and a transmit copy at the same time, with a table of frame-sync transitions (steady low, steady high, rising, falling) and side inputs. A mode that responds to the wrong polarity or kind of event shows up as a missing or extra pulse, and so does a mode that answers a side input it should ignore. Directed cases measure the exact cycle of an edge-triggered pulse through the synchronizer. They also hold a level condition across a frame-done to show both the one-shot behaviour and the re-arm. A disable in the same cycle as a trigger must suppress that pulse.

// File: rtl/sport_start_pkg.sv
package sport_start_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SM_CONT  = 3'd0,
    SM_PEER  = 3'd1,
    SM_LOW   = 3'd2,
    SM_HIGH  = 3'd3,
    SM_FALL  = 3'd4,
    SM_RISE  = 3'd5,
    SM_ANY   = 3'd6,
    SM_MATCH = 3'd7
  } start_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } start_state_e;
endpackage

// File: rtl/sport_fsync_sync.sv
module sport_fsync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_in,
  output logic fs_level,
  output logic fs_rise,
  output logic fs_fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], fsync_in};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign fs_level = chain_q[STAGES-1];
  assign fs_rise  = chain_q[STAGES-1] & ~prev_q;
  assign fs_fall  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sport_trig_decode.sv
module sport_trig_decode
  import sport_start_pkg::*;
#(
  parameter bit IS_RX = 1'b1
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              fs_level,
  input  logic              fs_rise,
  input  logic              fs_fall,
  input  logic              peer_start,
  input  logic              word_wr,
  input  logic              cmp_match,
  output logic              trig
);
  logic cont_trig, match_trig;

  generate
    if (IS_RX) begin : g_rx
      assign cont_trig  = 1'b1;
      assign match_trig = cmp_match;
    end else begin : g_tx
      assign cont_trig  = word_wr;
      assign match_trig = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (start_mode_e'(mode))
      SM_CONT:  trig = cont_trig;
      SM_PEER:  trig = peer_start;
      SM_LOW:   trig = ~fs_level;
      SM_HIGH:  trig = fs_level;
      SM_FALL:  trig = fs_fall;
      SM_RISE:  trig = fs_rise;
      SM_ANY:   trig = fs_rise | fs_fall;
      SM_MATCH: trig = match_trig;
      default:  trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/sport_start_fsm.sv
module sport_start_fsm
  import sport_start_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trig,
  input  logic frame_done,
  output logic start_pulse,
  output logic armed,
  output logic busy
);
  start_state_e state_q, state_d;
  logic         fire;

  assign fire = enable & (state_q == ST_ARMED) & trig;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_ARMED;
        ST_ARMED: if (trig) state_d = ST_RUN;
        ST_RUN:   if (frame_done) state_d = ST_ARMED;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign start_pulse = fire;
  assign armed       = (state_q == ST_ARMED);
  assign busy        = (state_q == ST_RUN);
endmodule

// File: rtl/sport_start_sel.sv
module sport_start_sel
  import sport_start_pkg::*;
#(
  parameter bit IS_RX       = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [MODE_W-1:0] mode,
  input  logic              fsync_in,
  input  logic              peer_start,
  input  logic              word_wr,
  input  logic              cmp_match,
  input  logic              frame_done,
  output logic              start_pulse,
  output logic              armed,
  output logic              busy
);
  logic fs_level, fs_rise, fs_fall, trig;

  sport_fsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync_in (fsync_in),
    .fs_level (fs_level),
    .fs_rise  (fs_rise),
    .fs_fall  (fs_fall)
  );

  sport_trig_decode #(.IS_RX(IS_RX)) u_dec (
    .mode       (mode),
    .fs_level   (fs_level),
    .fs_rise    (fs_rise),
    .fs_fall    (fs_fall),
    .peer_start (peer_start),
    .word_wr    (word_wr),
    .cmp_match  (cmp_match),
    .trig       (trig)
  );

  sport_start_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .trig        (trig),
    .frame_done  (frame_done),
    .start_pulse (start_pulse),
    .armed       (armed),
    .busy        (busy)
  );
endmodule

// File: rtl/sport_start_sel_chk.sv
module sport_start_sel_chk #(
  parameter bit IS_RX = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [2:0] mode,
  input logic       peer_start,
  input logic       frame_done,
  input logic       start_pulse,
  input logic       armed,
  input logic       busy
);
  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !enable |-> !start_pulse); // R2
  AST_PEER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (enable && armed && mode == 3'd1 && peer_start) |-> start_pulse); // R4
  AST_TX_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (!IS_RX && mode == 3'd7) |-> !start_pulse); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> !start_pulse); // R9
  AST_PULSE_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> busy); // R9
  AST_DONE_REARM: assert property (@(posedge clk) disable iff (!rst_n) (busy && frame_done && enable) |=> armed); // R9
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(armed && busy)); // R9
  AST_PULSE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |-> armed); // R10
endmodule

bind sport_start_sel sport_start_sel_chk #(.IS_RX(IS_RX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .mode        (mode),
  .peer_start  (peer_start),
  .frame_done  (frame_done),
  .start_pulse (start_pulse),
  .armed       (armed),
  .busy        (busy)
);

// File: tb/sport_start_sel_tb.sv
module sport_start_sel_tb;
  logic clk = 1'b0;
  logic rst_n, enable, fsync_in, peer_start, word_wr, cmp_match, frame_done;
  logic [2:0] mode;
  logic rx_pulse, rx_armed, rx_busy, tx_pulse, tx_armed, tx_busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sport_start_sel #(.IS_RX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .fsync_in(fsync_in),
    .peer_start(peer_start), .word_wr(word_wr), .cmp_match(cmp_match),
    .frame_done(frame_done), .start_pulse(rx_pulse), .armed(rx_armed), .busy(rx_busy));

  sport_start_sel #(.IS_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .fsync_in(fsync_in),
    .peer_start(peer_start), .word_wr(word_wr), .cmp_match(cmp_match),
    .frame_done(frame_done), .start_pulse(tx_pulse), .armed(tx_armed), .busy(tx_busy));

  // {mode[2:0], fs_before, fs_after, peer, wr, cmp, exp_rx, exp_tx}
  localparam int NV = 18;
  localparam logic [9:0] VEC [NV] = '{
    {3'd0, 1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1,1'b0}, // R3 rx free, tx waits
    {3'd0, 1'b0,1'b0, 1'b0,1'b1,1'b0, 1'b1,1'b1}, // R3 word written
    {3'd1, 1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b1,1'b1}, // R4 peer
    {3'd1, 1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,1'b0}, // R4/R10 no peer
    {3'd2, 1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1,1'b1}, // R5 low
    {3'd2, 1'b1,1'b1, 1'b0,1'b0,1'b0, 1'b0,1'b0}, // R5
    {3'd3, 1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b1,1'b1}, // R5 high
    {3'd3, 1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b0,1'b0}, // R5/R10
    {3'd4, 1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1,1'b1}, // R6 falling
    {3'd4, 1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b0,1'b0}, // R6 wrong edge
    {3'd5, 1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b1,1'b1}, // R6 rising
    {3'd5, 1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b0,1'b0}, // R6 wrong edge
    {3'd6, 1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b1,1'b1}, // R7 rise
    {3'd6, 1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1,1'b1}, // R7 fall
    {3'd6, 1'b1,1'b1, 1'b0,1'b0,1'b0, 1'b0,1'b0}, // R7 no change
    {3'd7, 1'b0,1'b0, 1'b0,1'b0,1'b1, 1'b1,1'b0}, // R8 match
    {3'd7, 1'b0,1'b1, 1'b1,1'b1,1'b0, 1'b0,1'b0}, // R8/R10 no match
    {3'd4, 1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b0,1'b0}  // R10 side inputs ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    peer_start = 1'b0; word_wr = 1'b0; cmp_match = 1'b0; frame_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; mode = 3'd0; fsync_in = 1'b0; quiet();
    repeat (3) @(negedge clk);
    check(rx_pulse == 0 && rx_armed == 0 && rx_busy == 0, "R1 in reset", {rx_pulse, rx_armed, rx_busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_pulse == 0 && rx_armed == 0 && rx_busy == 0 && tx_armed == 0, "R1 after release",
          {rx_pulse, rx_armed, rx_busy}, 0);

    for (int i = 0; i < NV; i++) begin
      int crx, ctx;
      enable = 1'b0; quiet();
      mode = VEC[i][9:7]; fsync_in = VEC[i][6];
      repeat (4) @(negedge clk);
      fsync_in = VEC[i][5]; peer_start = VEC[i][4]; word_wr = VEC[i][3]; cmp_match = VEC[i][2];
      enable = 1'b1;
      crx = 0; ctx = 0;
      repeat (6) begin
        @(negedge clk);
        crx += int'(rx_pulse);
        ctx += int'(tx_pulse);
      end
      check(crx == int'(VEC[i][1]), $sformatf("R3-R8 vec%0d rx", i), crx, int'(VEC[i][1]));
      check(ctx == int'(VEC[i][0]), $sformatf("R3-R8 vec%0d tx", i), ctx, int'(VEC[i][0]));
    end

    // R2: arming and disable in the same cycle as a trigger
    enable = 1'b0; quiet(); mode = 3'd1; fsync_in = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(rx_armed == 1 && rx_busy == 0, "R2 armed after enable", rx_armed, 1);
    enable = 1'b0; peer_start = 1'b1;
    #1;
    check(rx_pulse == 0 && tx_pulse == 0, "R2 no pulse while disabled", rx_pulse, 0);
    @(negedge clk);
    check(rx_armed == 0 && rx_pulse == 0, "R2 idle after disable", rx_armed, 0);
    quiet();

    // R6: exact latency of a rising edge
    mode = 3'd5; fsync_in = 1'b0; enable = 1'b1;
    repeat (4) @(negedge clk);
    fsync_in = 1'b1;
    @(negedge clk);
    check(rx_pulse == 0, "R6 not yet after one edge", rx_pulse, 0);
    @(negedge clk);
    check(rx_pulse == 1 && tx_pulse == 1, "R6 pulse after second edge", rx_pulse, 1);
    @(negedge clk);
    check(rx_pulse == 0 && rx_busy == 1, "R6 single pulse", rx_pulse, 0);

    // R9: held level fires once, rearms on frame_done
    enable = 1'b0; mode = 3'd3;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(rx_pulse == 1, "R9 level fires", rx_pulse, 1);
    @(negedge clk);
    check(rx_pulse == 0 && rx_busy == 1, "R9 busy ignores level", rx_pulse, 0);
    @(negedge clk);
    check(rx_pulse == 0 && rx_busy == 1, "R9 still busy", rx_busy, 1);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    check(rx_armed == 1 && rx_pulse == 1, "R9 rearm and refire", rx_armed, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule